// File: doc/BRIEF.md
# Coarse-Grained Instruction Sequencer for a Matrix Accelerator

This block takes fixed 96-bit (12-byte) instructions from a valid/ready stream. It decodes each one and hands it to one of four execution stations: weight fetch, matrix multiply, activation, and host transfer. A dispatch is a one-cycle start pulse on the station's bit of `stStart`. With the pulse come the operand fields of the instruction. Each station reports completion with a one-cycle pulse on its bit of `stDone`. A station may stay busy for thousands of cycles, and the sequencer keeps dispatching to the other stations in the meantime.

Readiness is tracked by a small scoreboard. It holds one busy bit per station. The weight-fetch bit doubles as the "weights pending" flag and the activation bit doubles as the "activation pending" flag. A weight fetch retires as soon as its address has been handed out, so later work can overlap the fetch. A matrix multiply, however, stalls until the fetched weights have arrived. Two barrier instructions order work explicitly:
- The activation barrier makes the next matrix multiply wait for outstanding activations.
- The full barrier drains every station.

The remaining instructions act inside the block:
- An interrupt instruction pulses `irq`.
- A tag instruction updates a readable tag register.
- A configuration instruction updates a readable configuration register.
- A halt instruction freezes intake until reset.

Top module: `cisc_sequencer`

## Requirements
- R1: `instReady` is high only while no instruction is held and the block is not halted. An instruction is taken on a cycle where `instValid` and `instReady` are both high, and `instReady` is low in the following cycle.
- R2: The instruction word is laid out least-significant byte first: bytes 2..0 are the buffer address, bytes 4..3 the accumulator address, bytes 8..5 the length, bytes 10..9 the flags, and byte 11 the opcode. A dispatch raises exactly one bit of `stStart` for one cycle. In that cycle `stUbAddr`, `stAccAddr`, `stLen`, `stFlags` and `stOp` carry that instruction's fields and opcode.
- R3: Opcode to station mapping: 0x05 weight read goes to bit 0; 0x06 matrix multiply goes to bit 1; 0x07 activate goes to bit 2; 0x01 host read, 0x02 host write, 0x03 alternate host read and 0x04 alternate host write go to bit 3.
- R4: A station never receives a second start between a start and its done pulse.
- R5: A weight read retires when dispatched. Later instructions for other stations dispatch while the weight fetch is still outstanding.
- R6: A matrix multiply is not dispatched while a weight fetch is outstanding.
- R7: After an activation barrier (0x09), the next matrix multiply is not dispatched while any activation is outstanding.
- R8: After a full barrier (0x0A), no later instruction dispatches until every station has returned done.
- R9: Each interrupt instruction (0x0B) produces exactly one single-cycle pulse on `irq`.
- R10: A tag instruction (0x0C) copies its flags into `dbgTag`. A configuration instruction (0x08) copies its flags into `cfgWord`.
- R11: After a halt instruction (0x0D), `instReady` stays low until reset, and no further instruction is dispatched.
- R12: A nop (0x00) or an unassigned opcode retires without any start, `irq` pulse, or register change.
- R13: Station starts occur in program order.
- R14: After reset, `instReady` is 1, and `stStart`, `irq`, `dbgTag` and `cfgWord` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction word offered |
| instReady | output | 1 | Instruction word can be taken |
| instData | input | 96 | Instruction word |
| stStart | output | 4 | One-cycle start per station (0 weight, 1 matmul, 2 activation, 3 host) |
| stOp | output | 8 | Opcode of the dispatched instruction |
| stUbAddr | output | 24 | Unified-buffer address of the dispatched instruction |
| stAccAddr | output | 16 | Accumulator address of the dispatched instruction |
| stLen | output | 32 | Length field of the dispatched instruction |
| stFlags | output | 16 | Flags of the dispatched instruction |
| stDone | input | 4 | One-cycle completion pulse per station |
| irq | output | 1 | Host interrupt pulse |
| dbgTag | output | 16 | Last tag written by a tag instruction |
| cfgWord | output | 16 | Last configuration written by a configuration instruction |

## Verification
The bench uses the default field widths, so the full 12-byte word is exercised, including flags and length values that span every byte. Station latency is a bench setting rather than a design parameter. The bench uses 2000-cycle latencies to show weight-fetch overlap and barrier stalls over long windows. It uses short random latencies of 1 to 25 cycles to drive many stalls, barrier hits and order checks within a few thousand cycles.

// File: rtl/cisc_seq_pkg.sv
package cisc_seq_pkg;

  localparam int NUM_ST = 4;
  localparam int OP_W   = 8;

  // station slots in the start/done vectors
  localparam int ST_WGT  = 0;
  localparam int ST_MM   = 1;
  localparam int ST_ACT  = 2;
  localparam int ST_HOST = 3;

  localparam logic [OP_W-1:0] OP_NOP      = 8'h00;
  localparam logic [OP_W-1:0] OP_HRD      = 8'h01;
  localparam logic [OP_W-1:0] OP_HWR      = 8'h02;
  localparam logic [OP_W-1:0] OP_HRD_ALT  = 8'h03;
  localparam logic [OP_W-1:0] OP_HWR_ALT  = 8'h04;
  localparam logic [OP_W-1:0] OP_WGT      = 8'h05;
  localparam logic [OP_W-1:0] OP_MM       = 8'h06;
  localparam logic [OP_W-1:0] OP_ACT      = 8'h07;
  localparam logic [OP_W-1:0] OP_CFG      = 8'h08;
  localparam logic [OP_W-1:0] OP_SYNC_ACT = 8'h09;
  localparam logic [OP_W-1:0] OP_SYNC_ALL = 8'h0A;
  localparam logic [OP_W-1:0] OP_IRQ      = 8'h0B;
  localparam logic [OP_W-1:0] OP_TAG      = 8'h0C;
  localparam logic [OP_W-1:0] OP_HALT     = 8'h0D;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHead;
    logic issue;
    logic loadTag;
    logic loadCfg;
  } dpStrobe_t;

  // which station an opcode targets, zero for in-sequencer instructions
  function automatic logic [NUM_ST-1:0] stationSel(input logic [OP_W-1:0] op);
    logic [NUM_ST-1:0] s;
    s = '0;
    case (op)
      OP_HRD, OP_HWR, OP_HRD_ALT, OP_HWR_ALT: s[ST_HOST] = 1'b1;
      OP_WGT:                                 s[ST_WGT]  = 1'b1;
      OP_MM:                                  s[ST_MM]   = 1'b1;
      OP_ACT:                                 s[ST_ACT]  = 1'b1;
      default:                                s          = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cisc_seq_sb.sv
module cisc_seq_sb
  import cisc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_ST-1:0] issueSel,
  input  logic [NUM_ST-1:0] stDone,
  input  logic              setBarrier,
  input  logic              clrBarrier,
  output logic [NUM_ST-1:0] busy,
  output logic              barrier
);

  // one outstanding flag per station; weight and activation slots
  // are the pending-weight and pending-activation flags
  for (genvar i = 0; i < NUM_ST; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            busy[i] <= 1'b0;
      else if (issueSel[i]) busy[i] <= 1'b1;
      else if (stDone[i])   busy[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           barrier <= 1'b0;
    else if (setBarrier) barrier <= 1'b1;
    else if (clrBarrier) barrier <= 1'b0;
  end

endmodule

// File: rtl/cisc_seq_ctrl.sv
module cisc_seq_ctrl
  import cisc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  output logic              instReady,
  input  logic [OP_W-1:0]   headOp,
  input  logic [NUM_ST-1:0] busy,
  input  logic              barrier,
  output logic [NUM_ST-1:0] issueSel,
  output logic              setBarrier,
  output logic              clrBarrier,
  output dpStrobe_t         strobe,
  output logic [NUM_ST-1:0] stStart,
  output logic              irq
);

  logic              headValid;
  logic              halted;
  logic [NUM_ST-1:0] sel;
  logic              canGo;
  logic              retire;
  logic              accept;

  assign instReady = !headValid && !halted;
  assign accept    = instValid && instReady;

  // dispatch conditions for the held instruction
  always_comb begin
    sel   = stationSel(headOp);
    canGo = 1'b1;
    if (|sel)
      canGo = ((sel & busy) == '0);
    if (headOp == OP_MM && (busy[ST_WGT] || (barrier && busy[ST_ACT])))
      canGo = 1'b0;
    if (headOp == OP_SYNC_ALL && (|busy))
      canGo = 1'b0;
  end

  assign retire     = headValid && canGo;
  assign issueSel   = retire ? sel : '0;
  assign setBarrier = retire && (headOp == OP_SYNC_ACT);
  assign clrBarrier = retire && (headOp == OP_MM);

  always_comb begin
    strobe          = '0;
    strobe.loadHead = accept;
    strobe.issue    = |issueSel;
    strobe.loadTag  = retire && (headOp == OP_TAG);
    strobe.loadCfg  = retire && (headOp == OP_CFG);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headValid <= 1'b0;
      halted    <= 1'b0;
      stStart   <= '0;
      irq       <= 1'b0;
    end else begin
      if (accept)      headValid <= 1'b1;
      else if (retire) headValid <= 1'b0;
      if (retire && headOp == OP_HALT) halted <= 1'b1;
      stStart <= issueSel;
      irq     <= retire && (headOp == OP_IRQ);
    end
  end

endmodule

// File: rtl/cisc_seq_dp.sv
module cisc_seq_dp
  import cisc_seq_pkg::*;
#(
  parameter  int UB_W   = 24,
  parameter  int ACC_W  = 16,
  parameter  int LEN_W  = 32,
  parameter  int FLG_W  = 16,
  localparam int INST_W = UB_W + ACC_W + LEN_W + FLG_W + OP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [INST_W-1:0] instData,
  output logic [OP_W-1:0]   headOp,
  output logic [OP_W-1:0]   stOp,
  output logic [UB_W-1:0]   stUbAddr,
  output logic [ACC_W-1:0]  stAccAddr,
  output logic [LEN_W-1:0]  stLen,
  output logic [FLG_W-1:0]  stFlags,
  output logic [FLG_W-1:0]  dbgTag,
  output logic [FLG_W-1:0]  cfgWord
);

  localparam int ACC_LO = UB_W;
  localparam int LEN_LO = ACC_LO + ACC_W;
  localparam int FLG_LO = LEN_LO + LEN_W;
  localparam int OP_LO  = FLG_LO + FLG_W;

  logic [UB_W-1:0]  hUb;
  logic [ACC_W-1:0] hAcc;
  logic [LEN_W-1:0] hLen;
  logic [FLG_W-1:0] hFlg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headOp <= OP_NOP;
      hUb    <= '0;
      hAcc   <= '0;
      hLen   <= '0;
      hFlg   <= '0;
    end else if (strobe.loadHead) begin
      headOp <= instData[OP_LO  +: OP_W];
      hUb    <= instData[0      +: UB_W];
      hAcc   <= instData[ACC_LO +: ACC_W];
      hLen   <= instData[LEN_LO +: LEN_W];
      hFlg   <= instData[FLG_LO +: FLG_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stOp      <= '0;
      stUbAddr  <= '0;
      stAccAddr <= '0;
      stLen     <= '0;
      stFlags   <= '0;
    end else if (strobe.issue) begin
      stOp      <= headOp;
      stUbAddr  <= hUb;
      stAccAddr <= hAcc;
      stLen     <= hLen;
      stFlags   <= hFlg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbgTag  <= '0;
      cfgWord <= '0;
    end else begin
      if (strobe.loadTag) dbgTag  <= hFlg;
      if (strobe.loadCfg) cfgWord <= hFlg;
    end
  end

endmodule

// File: rtl/cisc_sequencer.sv
module cisc_sequencer
  import cisc_seq_pkg::*;
#(
  parameter  int UB_W   = 24,
  parameter  int ACC_W  = 16,
  parameter  int LEN_W  = 32,
  parameter  int FLG_W  = 16,
  localparam int INST_W = UB_W + ACC_W + LEN_W + FLG_W + OP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  output logic              instReady,
  input  logic [INST_W-1:0] instData,
  output logic [NUM_ST-1:0] stStart,
  output logic [OP_W-1:0]   stOp,
  output logic [UB_W-1:0]   stUbAddr,
  output logic [ACC_W-1:0]  stAccAddr,
  output logic [LEN_W-1:0]  stLen,
  output logic [FLG_W-1:0]  stFlags,
  input  logic [NUM_ST-1:0] stDone,
  output logic              irq,
  output logic [FLG_W-1:0]  dbgTag,
  output logic [FLG_W-1:0]  cfgWord
);

  dpStrobe_t         strobe;
  logic [OP_W-1:0]   headOp;
  logic [NUM_ST-1:0] busy;
  logic [NUM_ST-1:0] issueSel;
  logic              barrier;
  logic              setBarrier;
  logic              clrBarrier;

  cisc_seq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .instValid  (instValid),
    .instReady  (instReady),
    .headOp     (headOp),
    .busy       (busy),
    .barrier    (barrier),
    .issueSel   (issueSel),
    .setBarrier (setBarrier),
    .clrBarrier (clrBarrier),
    .strobe     (strobe),
    .stStart    (stStart),
    .irq        (irq)
  );

  cisc_seq_sb uSb (
    .clk        (clk),
    .rstN       (rstN),
    .issueSel   (issueSel),
    .stDone     (stDone),
    .setBarrier (setBarrier),
    .clrBarrier (clrBarrier),
    .busy       (busy),
    .barrier    (barrier)
  );

  cisc_seq_dp #(
    .UB_W  (UB_W),
    .ACC_W (ACC_W),
    .LEN_W (LEN_W),
    .FLG_W (FLG_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .instData  (instData),
    .headOp    (headOp),
    .stOp      (stOp),
    .stUbAddr  (stUbAddr),
    .stAccAddr (stAccAddr),
    .stLen     (stLen),
    .stFlags   (stFlags),
    .dbgTag    (dbgTag),
    .cfgWord   (cfgWord)
  );

endmodule

// File: rtl/cisc_sequencer_chk.sv
module cisc_sequencer_chk
  import cisc_seq_pkg::*;
#(
  parameter int INST_W = 96,
  parameter int LEN_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic              instReady,
  input logic [INST_W-1:0] instData,
  input logic [NUM_ST-1:0] stStart,
  input logic [NUM_ST-1:0] stDone,
  input logic [LEN_W-1:0]  stLen,
  input logic              irq
);

  logic [NUM_ST-1:0] chkBusy;
  logic              haltSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkBusy  <= '0;
      haltSeen <= 1'b0;
    end else begin
      chkBusy <= (chkBusy & ~stDone) | stStart;
      if (instValid && instReady && instData[INST_W-1 -: OP_W] == OP_HALT)
        haltSeen <= 1'b1;
    end
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady) |=> !instReady);

  a_r2_start_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stStart));

  a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stLen) |-> (|stStart));

  for (genvar i = 0; i < NUM_ST; i++) begin : g_st
    a_r4_one_per_station: assert property (@(posedge clk) disable iff (!rstN)
      stStart[i] |-> !chkBusy[i]);
  end

  a_r6_mm_waits_weight: assert property (@(posedge clk) disable iff (!rstN)
    stStart[ST_MM] |-> !chkBusy[ST_WGT]);

  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  a_r11_halt_blocks: assert property (@(posedge clk) disable iff (!rstN)
    haltSeen |-> !instReady);

endmodule

bind cisc_sequencer cisc_sequencer_chk #(
  .INST_W (INST_W),
  .LEN_W  (LEN_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .instValid (instValid),
  .instReady (instReady),
  .instData  (instData),
  .stStart   (stStart),
  .stDone    (stDone),
  .stLen     (stLen),
  .irq       (irq)
);

// File: tb/cisc_sequencer_test.sv
module cisc_sequencer_test;
  import cisc_seq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int UB_W   = 24;
  localparam int ACC_W  = 16;
  localparam int LEN_W  = 32;
  localparam int FLG_W  = 16;
  localparam int INST_W = UB_W + ACC_W + LEN_W + FLG_W + OP_W;
  localparam int MAXQ   = 512;
  localparam int NRAND  = 200;
  localparam logic [7:0] POOL [16] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h05, 8'h06, 8'h06,
                                       8'h07, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h00};

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              instValid = 1'b0;
  logic [INST_W-1:0] instData = '0;
  logic              instReady;
  logic [3:0]        stStart;
  logic [7:0]        stOp;
  logic [UB_W-1:0]   stUbAddr;
  logic [ACC_W-1:0]  stAccAddr;
  logic [LEN_W-1:0]  stLen;
  logic [FLG_W-1:0]  stFlags;
  logic [3:0]        stDone = '0;
  logic              irq;
  logic [FLG_W-1:0]  dbgTag;
  logic [FLG_W-1:0]  cfgWord;

  always #(CLK_PERIOD/2) clk = ~clk;

  cisc_sequencer uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instReady(instReady),
    .instData(instData), .stStart(stStart), .stOp(stOp), .stUbAddr(stUbAddr),
    .stAccAddr(stAccAddr), .stLen(stLen), .stFlags(stFlags), .stDone(stDone),
    .irq(irq), .dbgTag(dbgTag), .cfgWord(cfgWord)
  );

  int checks = 0;
  int errors = 0;
  int expCount = 0;
  int gotCount = 0;
  int irqSeen = 0;
  int irqExp = 0;
  logic [FLG_W-1:0] tagExp = '0;
  logic [FLG_W-1:0] cfgExp = '0;
  bit barPend = 1'b0;
  bit idlePend = 1'b0;
  bit longMode = 1'b0;
  bit hostDuringWeight = 1'b0;
  bit prevIrq = 1'b0;
  bit [3:0] mBusy = '0;
  int cnt [4];
  int monK;
  bit [3:0] startedNow;

  int               expSt  [MAXQ];
  logic [7:0]       expOp  [MAXQ];
  logic [UB_W-1:0]  expUb  [MAXQ];
  logic [ACC_W-1:0] expAcc [MAXQ];
  logic [LEN_W-1:0] expLen [MAXQ];
  logic [FLG_W-1:0] expFlg [MAXQ];
  bit               expBar [MAXQ];
  bit               expIdle[MAXQ];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // station targeted by an opcode, from the requirement mapping
  function automatic int stationOf(input logic [7:0] op);
    case (op)
      8'h01, 8'h02, 8'h03, 8'h04: return 3;
      8'h05: return 0;
      8'h06: return 1;
      8'h07: return 2;
      default: return -1;
    endcase
  endfunction

  // station responders and start monitor
  always @(negedge clk) begin
    stDone = '0;
    startedNow = '0;
    if (stStart != 4'b0 && !$onehot(stStart))
      check(1'b0, "R2 start not one-hot", 64'(stStart), 64'(0));
    for (int i = 0; i < 4; i++) begin
      if (stStart[i]) begin
        monK = gotCount;
        startedNow[i] = 1'b1;
        if (monK >= expCount) begin
          check(1'b0, "R13 unexpected start", 64'(i), 64'(-1));
        end else begin
          check(expSt[monK] == i, "R3 station", 64'(i), 64'(expSt[monK]));
          check(stOp == expOp[monK] && stUbAddr == expUb[monK] && stAccAddr == expAcc[monK]
                && stLen == expLen[monK] && stFlags == expFlg[monK],
                "R2 start fields", {stOp, stUbAddr, stLen}, {expOp[monK], expUb[monK], expLen[monK]});
          if (i == 1) check(!mBusy[0], "R6 matmul during weight fetch", 64'(mBusy), 64'(0));
          if (expBar[monK]) check(!mBusy[2], "R7 matmul during activation", 64'(mBusy), 64'(0));
          if (expIdle[monK]) check(mBusy == 4'b0, "R8 start before drain", 64'(mBusy), 64'(0));
          if (i == 3 && mBusy[0]) hostDuringWeight = 1'b1;
        end
        check(!mBusy[i], "R4 start to busy station", 64'(i), 64'(0));
        gotCount++;
      end
    end
    for (int i = 0; i < 4; i++) begin
      if (startedNow[i]) begin
        mBusy[i] = 1'b1;
        cnt[i] = longMode ? 2000 : int'($urandom_range(25, 1));
      end else if (mBusy[i]) begin
        if (cnt[i] <= 1) begin
          stDone[i] = 1'b1;
          mBusy[i] = 1'b0;
        end else begin
          cnt[i] = cnt[i] - 1;
        end
      end
    end
    if (irq) begin
      irqSeen++;
      if (prevIrq) check(1'b0, "R9 irq wider than one cycle", 64'(2), 64'(1));
    end
    prevIrq = irq;
  end

  task automatic sendRaw(input logic [INST_W-1:0] d);
    @(negedge clk);
    instValid = 1'b1;
    instData = d;
    while (!instReady) @(negedge clk);
    @(negedge clk);
    instValid = 1'b0;
    check(!instReady, "R1 ready after accept", 64'(instReady), 64'(0));
  endtask

  task automatic issue(input logic [7:0] op, input logic [FLG_W-1:0] f,
                       input logic [LEN_W-1:0] l, input logic [ACC_W-1:0] a,
                       input logic [UB_W-1:0] u);
    int s;
    s = stationOf(op);
    if (s >= 0) begin
      expSt[expCount]   = s;
      expOp[expCount]   = op;
      expUb[expCount]   = u;
      expAcc[expCount]  = a;
      expLen[expCount]  = l;
      expFlg[expCount]  = f;
      expBar[expCount]  = (s == 1) && barPend;
      expIdle[expCount] = idlePend;
      idlePend = 1'b0;
      if (s == 1) barPend = 1'b0;
      expCount++;
    end
    case (op)
      8'h09: barPend = 1'b1;
      8'h0A: idlePend = 1'b1;
      8'h0B: irqExp++;
      8'h0C: tagExp = f;
      8'h08: cfgExp = f;
      default: ;
    endcase
    sendRaw({op, f, l, a, u});
  endtask

  task automatic issueRand(input logic [7:0] op);
    issue(op, FLG_W'($urandom), LEN_W'($urandom), ACC_W'($urandom), UB_W'($urandom));
  endtask

  task automatic drain();
    while (gotCount != expCount || mBusy != 4'b0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog expired actual=%0d expected=%0d", gotCount, expCount);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int g;
    int ic;
    int bad;
    void'($urandom(32'd7741));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R14 reset state
    check(instReady, "R14 ready after reset", 64'(instReady), 64'(1));
    check(stStart == 4'b0, "R14 no start after reset", 64'(stStart), 64'(0));
    check(!irq, "R14 irq after reset", 64'(irq), 64'(0));
    check(dbgTag == '0 && cfgWord == '0, "R14 registers after reset", {dbgTag, cfgWord}, 64'(0));

    // R5 / R6: long weight fetch overlapped by host work, matmul waits
    longMode = 1'b1;
    issue(8'h05, 16'h0011, 32'h0000_0100, 16'h0001, 24'h00_0040);
    issue(8'h01, 16'h0022, 32'h0010_0020, 16'h0002, 24'h12_3456);
    issue(8'h06, 16'h8001, 32'hFFFF_0001, 16'hABCD, 24'hFE_DCBA);
    drain();
    check(hostDuringWeight, "R5 host overlapped weight fetch", 64'(hostDuringWeight), 64'(1));

    // R7: long activation, barrier, then matmul
    issue(8'h07, 16'h0003, 32'h0000_0040, 16'h0100, 24'h00_0200);
    issue(8'h09, 16'h0000, 32'h0, 16'h0, 24'h0);
    issue(8'h06, 16'h0004, 32'h0008_0008, 16'h0200, 24'h00_0300);
    drain();
    longMode = 1'b0;

    // R8: full barrier after several stations
    issueRand(8'h03);
    issueRand(8'h07);
    issueRand(8'h05);
    issue(8'h0A, 16'h0, 32'h0, 16'h0, 24'h0);
    issueRand(8'h04);
    drain();

    // R10 tag and config
    issue(8'h0C, 16'hBEEF, 32'h0, 16'h0, 24'h0);
    issue(8'h08, 16'h1234, 32'h0, 16'h0, 24'h0);
    repeat (3) @(negedge clk);
    check(dbgTag == 16'hBEEF, "R10 tag register", 64'(dbgTag), 64'(16'hBEEF));
    check(cfgWord == 16'h1234, "R10 config register", 64'(cfgWord), 64'(16'h1234));

    // R9 single interrupt
    ic = irqSeen;
    issue(8'h0B, 16'h0, 32'h0, 16'h0, 24'h0);
    repeat (4) @(negedge clk);
    check(irqSeen == ic + 1, "R9 one irq pulse", 64'(irqSeen - ic), 64'(1));

    // R12 nop and unassigned opcode have no effect
    g = gotCount;
    ic = irqSeen;
    issueRand(8'h00);
    sendRaw({8'hFF, 16'h5A5A, 32'hDEAD_BEEF, 16'h7777, 24'h33_3333});
    repeat (6) @(negedge clk);
    check(gotCount == g, "R12 no start from nop", 64'(gotCount), 64'(g));
    check(irqSeen == ic, "R12 no irq from nop", 64'(irqSeen), 64'(ic));
    check(dbgTag == tagExp && cfgWord == cfgExp, "R12 registers unchanged",
          {dbgTag, cfgWord}, {tagExp, cfgExp});
    check(instReady, "R12 nop retired", 64'(instReady), 64'(1));

    // constrained random program
    for (int n = 0; n < NRAND; n++) begin
      issueRand(POOL[$urandom_range(15, 0)]);
      if ($urandom_range(3, 0) == 0) repeat ($urandom_range(6, 1)) @(negedge clk);
    end
    drain();
    check(gotCount == expCount, "R13 all starts in order", 64'(gotCount), 64'(expCount));
    check(irqSeen == irqExp, "R9 irq count", 64'(irqSeen), 64'(irqExp));
    check(dbgTag == tagExp, "R10 final tag", 64'(dbgTag), 64'(tagExp));
    check(cfgWord == cfgExp, "R10 final config", 64'(cfgWord), 64'(cfgExp));

    // R11 halt
    issue(8'h0D, 16'h0, 32'h0, 16'h0, 24'h0);
    g = gotCount;
    bad = 0;
    @(negedge clk);
    instValid = 1'b1;
    instData = {8'h01, 16'h0001, 32'h1, 16'h1, 24'h1};
    repeat (40) begin
      @(negedge clk);
      if (instReady) bad++;
    end
    instValid = 1'b0;
    check(bad == 0, "R11 ready low after halt", 64'(bad), 64'(0));
    repeat (5) @(negedge clk);
    check(gotCount == g, "R11 no dispatch after halt", 64'(gotCount), 64'(g));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule